// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block arbitrates five interrupt inputs on behalf of an 8-bit processor core. Two restart inputs and a general request input are sensed as high levels. A third restart input is captured on its rising edge into a request latch. A non-maskable input counts only after it rises, and only while it stays high. The block holds the global interrupt enable, a mask bit for each of the three restart inputs, the edge latch, a saved copy of the enable for the non-maskable case, and a serial output bit. The core reaches all of this through a set-mask write and a read-mask value.

The core raises a boundary strobe in the second-to-last clock of an instruction. In that cycle the block chooses the highest-priority eligible source. One clock later it pulses an acceptance output for a single cycle. Along with that pulse it gives either a restart vector or a request for an external acknowledge cycle. The core uses the acceptance pulse to hold its program counter and to start the restart sequence. Stack handling and bus cycles are the core's responsibility.

Top module: `restart_irq_ctrl`

## Requirements
- R1: The priority order is `trapIn`, then `rst75In`, then `rst65In`, then `rst55In`, then `intrIn`. The vectors are 0x24 for `trapIn`, 0x3C for `rst75In`, 0x34 for `rst65In` and 0x2C for `rst55In`. Accepting `intrIn` raises `intaReq` with `vectorOut` = 0x00.
- R2: A source is chosen only in a cycle where `boundary` is high. `irqTaken` is high for exactly the one clock after that cycle, and stays low whenever `boundary` was low.
- R3: `rst55In`, `rst65In` and `intrIn` are taken only while they are high, the enable is set, and (for the restart inputs) the mask bit is 0. Mask bit 0 blocks `rst55In`, bit 1 blocks `rst65In` and bit 2 blocks `rst75In`.
- R4: A rising edge on `rst75In` sets its latch even while it is masked. The latch is shown in `rimData[6]` and is cleared when that source is accepted.
- R5: A set-mask write with `simData[4]` = 1 clears the `rst75In` latch. Reset also clears it.
- R6: `trapIn` ignores the enable and all masks. It is taken only after a rising edge, and only while it is still high at the boundary. Once taken, it is not taken again until it has gone low and then high again.
- R7: Accepting any source clears the enable. `eiReq` sets the enable and `diReq` clears it. `rimData[3]` shows the enable.
- R8: After a `trapIn` acceptance, `rimData[3]` shows the enable as it was just before that acceptance. A `rimReq` pulse ends this, and from then on `rimData[3]` shows the current enable.
- R9: The masks are loaded from `simData[2:0]` only on a set-mask write with `simData[3]` = 1. Reset sets all three masks and clears the enable.
- R10: `sodOut` takes the value of `simData[7]` only on a set-mask write with `simData[6]` = 1. Reset sets `sodOut` to 0.
- R11: `rimData` bits, from 7 down to 0, are: SID level, `rst75In` latch, `rst65In` level, `rst55In` level, enable bit, and masks 2..0.
- R12: Every input passes through a two-flop synchronizer. A level change becomes visible in `rimData` after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trapIn | input | 1 | Non-maskable request |
| rst75In | input | 1 | Edge-captured restart request |
| rst65In | input | 1 | Level restart request |
| rst55In | input | 1 | Level restart request |
| intrIn | input | 1 | General request that needs an acknowledge cycle |
| sidIn | input | 1 | Serial input bit |
| boundary | input | 1 | Core is at the interrupt sampling clock |
| eiReq | input | 1 | Enable-interrupts operation |
| diReq | input | 1 | Disable-interrupts operation |
| simReq | input | 1 | Set-mask write strobe |
| simData | input | 8 | Set-mask write data |
| rimReq | input | 1 | Read-mask operation performed |
| rimData | output | 8 | Read-mask value |
| irqTaken | output | 1 | Acceptance pulse; hold the program counter |
| vectorOut | output | 8 | Restart vector for the accepted source |
| intaReq | output | 1 | Run an external acknowledge cycle |
| sodOut | output | 1 | Serial output bit |

## Verification
The assertions check, on every cycle, these properties: acceptance follows a boundary strobe and lasts one clock; an acknowledge request never comes with a vector, and a vector is always one of the four legal values; the masks and the serial output bit change only on a qualifying set-mask write; and a lowest-restart acceptance had that input high and unmasked. The bench's scenarios show the rest. These are the full priority order under every mix of enable, masks and active inputs, the edge capture while masked, the non-maskable input's need to be re-armed, the one-shot visibility of the saved enable, and the synchronizer delay.

// File: rtl/restart_irq_pkg.sv
package restart_irq_pkg;

  localparam logic [7:0] VEC_TRAP = 8'h24;
  localparam logic [7:0] VEC_R75  = 8'h3C;
  localparam logic [7:0] VEC_R65  = 8'h34;
  localparam logic [7:0] VEC_R55  = 8'h2C;
  localparam logic [7:0] VEC_NONE = 8'h00;

  // number of synchronized pins: trap, r75, r65, r55, intr, sid
  localparam int unsigned PIN_COUNT = 6;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_TRAP,
    SRC_R75,
    SRC_R65,
    SRC_R55,
    SRC_INTR
  } irqSrc_e;

  // state the control reads from the datapath
  typedef struct packed {
    logic       trapQual;
    logic       r75Latch;
    logic       r65Lvl;
    logic       r55Lvl;
    logic       intrLvl;
    logic       intEn;
    logic [2:0] mask;
  } irqStatus_t;

  // strobes the control sends to the datapath
  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic saveShadow;
    logic dropShadow;
    logic clrR75;
    logic clrTrap;
    logic loadMask;
    logic loadSod;
  } irqStrobe_t;

endpackage

// File: rtl/restart_irq_sync.sv
module restart_irq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/restart_irq_path.sv
module restart_irq_path
  import restart_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trapIn,
  input  logic       rst75In,
  input  logic       rst65In,
  input  logic       rst55In,
  input  logic       intrIn,
  input  logic       sidIn,
  input  logic [7:0] simData,
  input  irqStrobe_t strb,
  output irqStatus_t status,
  output logic [7:0] rimData,
  output logic       sodOut
);

  logic [PIN_COUNT-1:0] rawPins;
  logic [PIN_COUNT-1:0] syncPins;

  assign rawPins = {sidIn, intrIn, rst55In, rst65In, rst75In, trapIn};

  restart_irq_sync #(
    .WIDTH (PIN_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawPins),
    .dout(syncPins)
  );

  logic trapLvl, r75Lvl, r65Lvl, r55Lvl, intrLvl, sidLvl;
  assign trapLvl = syncPins[0];
  assign r75Lvl  = syncPins[1];
  assign r65Lvl  = syncPins[2];
  assign r55Lvl  = syncPins[3];
  assign intrLvl = syncPins[4];
  assign sidLvl  = syncPins[5];

  logic r75Prev, trapPrev;
  logic r75Latch, trapLatch;
  logic intEn, shadowEn, shadowValid;
  logic [2:0] mask;
  logic sodReg;

  logic r75Rise, trapRise;
  assign r75Rise  = r75Lvl & ~r75Prev;
  assign trapRise = trapLvl & ~trapPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r75Prev  <= 1'b0;
      trapPrev <= 1'b0;
    end else begin
      r75Prev  <= r75Lvl;
      trapPrev <= trapLvl;
    end
  end

  // edge latch for the high restart; a fresh edge outranks any clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            r75Latch <= 1'b0;
    else if (r75Rise)     r75Latch <= 1'b1;
    else if (strb.clrR75) r75Latch <= 1'b0;
  end

  // edge half of the non-maskable qualifier
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             trapLatch <= 1'b0;
    else if (trapRise)     trapLatch <= 1'b1;
    else if (strb.clrTrap) trapLatch <= 1'b0;
  end

  // global enable: a clear wins over a set in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           intEn <= 1'b0;
    else if (strb.clrEn) intEn <= 1'b0;
    else if (strb.setEn) intEn <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowEn    <= 1'b0;
      shadowValid <= 1'b0;
    end else if (strb.saveShadow) begin
      shadowEn    <= intEn;
      shadowValid <= 1'b1;
    end else if (strb.dropShadow) begin
      shadowValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              mask <= 3'b111;
    else if (strb.loadMask) mask <= simData[2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sodReg <= 1'b0;
    else if (strb.loadSod) sodReg <= simData[7];
  end

  always_comb begin
    status          = '0;
    status.trapQual = trapLatch & trapLvl;
    status.r75Latch = r75Latch;
    status.r65Lvl   = r65Lvl;
    status.r55Lvl   = r55Lvl;
    status.intrLvl  = intrLvl;
    status.intEn    = intEn;
    status.mask     = mask;
  end

  assign rimData = {sidLvl, r75Latch, r65Lvl, r55Lvl,
                    (shadowValid ? shadowEn : intEn), mask};
  assign sodOut  = sodReg;

endmodule

// File: rtl/restart_irq_ctl.sv
module restart_irq_ctl
  import restart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       boundary,
  input  logic       eiReq,
  input  logic       diReq,
  input  logic       simReq,
  input  logic [7:0] simData,
  input  logic       rimReq,
  input  irqStatus_t status,
  output irqStrobe_t strb,
  output logic       irqTaken,
  output logic [7:0] vectorOut,
  output logic       intaReq
);

  irqSrc_e pick;

  always_comb begin
    pick = SRC_NONE;
    if (boundary) begin
      if (status.trapQual)                              pick = SRC_TRAP;
      else if (status.intEn) begin
        if (status.r75Latch && !status.mask[2])         pick = SRC_R75;
        else if (status.r65Lvl && !status.mask[1])      pick = SRC_R65;
        else if (status.r55Lvl && !status.mask[0])      pick = SRC_R55;
        else if (status.intrLvl)                        pick = SRC_INTR;
      end
    end
  end

  function automatic logic [7:0] vecOf(irqSrc_e src);
    case (src)
      SRC_TRAP: vecOf = VEC_TRAP;
      SRC_R75:  vecOf = VEC_R75;
      SRC_R65:  vecOf = VEC_R65;
      SRC_R55:  vecOf = VEC_R55;
      default:  vecOf = VEC_NONE;
    endcase
  endfunction

  always_comb begin
    strb            = '0;
    strb.clrEn      = (pick != SRC_NONE) | diReq;
    strb.setEn      = eiReq;
    strb.saveShadow = (pick == SRC_TRAP);
    strb.clrTrap    = (pick == SRC_TRAP);
    strb.dropShadow = rimReq;
    strb.clrR75     = (pick == SRC_R75) | (simReq & simData[4]);
    strb.loadMask   = simReq & simData[3];
    strb.loadSod    = simReq & simData[6];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqTaken  <= 1'b0;
      vectorOut <= VEC_NONE;
      intaReq   <= 1'b0;
    end else begin
      irqTaken  <= (pick != SRC_NONE);
      vectorOut <= vecOf(pick);
      intaReq   <= (pick == SRC_INTR);
    end
  end

endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
  import restart_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trapIn,
  input  logic       rst75In,
  input  logic       rst65In,
  input  logic       rst55In,
  input  logic       intrIn,
  input  logic       sidIn,
  input  logic       boundary,
  input  logic       eiReq,
  input  logic       diReq,
  input  logic       simReq,
  input  logic [7:0] simData,
  input  logic       rimReq,
  output logic [7:0] rimData,
  output logic       irqTaken,
  output logic [7:0] vectorOut,
  output logic       intaReq,
  output logic       sodOut
);

  irqStatus_t status;
  irqStrobe_t strb;

  restart_irq_path #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .trapIn (trapIn),
    .rst75In(rst75In),
    .rst65In(rst65In),
    .rst55In(rst55In),
    .intrIn (intrIn),
    .sidIn  (sidIn),
    .simData(simData),
    .strb   (strb),
    .status (status),
    .rimData(rimData),
    .sodOut (sodOut)
  );

  restart_irq_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .boundary (boundary),
    .eiReq    (eiReq),
    .diReq    (diReq),
    .simReq   (simReq),
    .simData  (simData),
    .rimReq   (rimReq),
    .status   (status),
    .strb     (strb),
    .irqTaken (irqTaken),
    .vectorOut(vectorOut),
    .intaReq  (intaReq)
  );

endmodule

// File: rtl/restart_irq_ctrl_chk.sv
module restart_irq_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       trapIn,
  input logic       rst75In,
  input logic       rst65In,
  input logic       rst55In,
  input logic       intrIn,
  input logic       sidIn,
  input logic       boundary,
  input logic       eiReq,
  input logic       diReq,
  input logic       simReq,
  input logic [7:0] simData,
  input logic       rimReq,
  input logic [7:0] rimData,
  input logic       irqTaken,
  input logic [7:0] vectorOut,
  input logic       intaReq,
  input logic       sodOut
);

  a_r2_take_after_boundary: assert property (@(posedge clk) disable iff (!rstN)
    irqTaken |-> $past(boundary));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqTaken |=> !irqTaken);

  a_r1_ack_has_no_vector: assert property (@(posedge clk) disable iff (!rstN)
    intaReq |-> (irqTaken && vectorOut == 8'h00));

  a_r1_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    (irqTaken && !intaReq) |->
      (vectorOut == 8'h24 || vectorOut == 8'h3C ||
       vectorOut == 8'h34 || vectorOut == 8'h2C));

  a_r9_masks_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(simReq && simData[3]) |=> $stable(rimData[2:0]));

  a_r10_sod_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(simReq && simData[6]) |=> $stable(sodOut));

  a_r3_low_restart_gated: assert property (@(posedge clk) disable iff (!rstN)
    (irqTaken && vectorOut == 8'h2C) |-> $past(rimData[4] && !rimData[0]));

endmodule

bind restart_irq_ctrl restart_irq_ctrl_chk u_chk (.*);

// File: tb/tb_restart_irq_ctrl.sv
module tb_restart_irq_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic       trapIn, rst75In, rst65In, rst55In, intrIn, sidIn;
  logic       boundary, eiReq, diReq, simReq, rimReq;
  logic [7:0] simData;
  logic [7:0] rimData;
  logic       irqTaken;
  logic [7:0] vectorOut;
  logic       intaReq;
  logic       sodOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  restart_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .trapIn(trapIn), .rst75In(rst75In),
    .rst65In(rst65In), .rst55In(rst55In), .intrIn(intrIn), .sidIn(sidIn),
    .boundary(boundary), .eiReq(eiReq), .diReq(diReq), .simReq(simReq),
    .simData(simData), .rimReq(rimReq), .rimData(rimData),
    .irqTaken(irqTaken), .vectorOut(vectorOut), .intaReq(intaReq),
    .sodOut(sodOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {trapIn, rst75In, rst65In, rst55In, intrIn, sidIn} = '0;
    {boundary, eiReq, diReq, simReq, rimReq} = '0;
    simData = 8'h00;
    waitCycles(2);
    rstN = 1'b1;
    waitCycles(1);
  endtask

  task automatic hitBoundary();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic sim(input logic [7:0] d);
    simReq = 1'b1;
    simData = d;
    @(negedge clk);
    simReq = 1'b0;
    simData = 8'h00;
  endtask

  task automatic ei();
    eiReq = 1'b1;
    @(negedge clk);
    eiReq = 1'b0;
  endtask

  task automatic di();
    diReq = 1'b1;
    @(negedge clk);
    diReq = 1'b0;
  endtask

  task automatic rim();
    rimReq = 1'b1;
    @(negedge clk);
    rimReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R9 R10 R11 reset state: masks set, enable clear, SOD low
    check("R9 reset rimData", rimData, 8'h07);
    check("R10 reset sodOut", {7'b0, sodOut}, 8'h00);
    check("R2 reset irqTaken", {7'b0, irqTaken}, 8'h00);

    // sweep every mix of inputs, enable and masks
    for (int c = 0; c < 512; c++) begin
      logic tp, r7, r6, r5, it, en;
      logic [2:0] m;
      logic [7:0] expVec;
      logic expTake, expInta;
      tp = c[0]; r7 = c[1]; r6 = c[2]; r5 = c[3]; it = c[4]; en = c[5];
      m = c[8:6];
      doReset();
      sim({5'b00001, m});
      if (en) ei();
      trapIn = tp; rst75In = r7; rst65In = r6; rst55In = r5; intrIn = it;
      waitCycles(4);
      check("R4 R11 pending bits", {1'b0, rimData[6:4]}, {1'b0, r7, r6, r5});
      check("R9 masks loaded", {5'b0, rimData[2:0]}, {5'b0, m});
      expTake = 1'b1; expInta = 1'b0; expVec = 8'h00;
      if (tp)                    expVec = 8'h24;
      else if (en && r7 && !m[2]) expVec = 8'h3C;
      else if (en && r6 && !m[1]) expVec = 8'h34;
      else if (en && r5 && !m[0]) expVec = 8'h2C;
      else if (en && it)          expInta = 1'b1;
      else                        expTake = 1'b0;
      hitBoundary();
      check("R1 R3 R6 taken", {7'b0, irqTaken}, {7'b0, expTake});
      check("R1 vector", vectorOut, expVec);
      check("R1 intaReq", {7'b0, intaReq}, {7'b0, expInta});
      if (expTake && tp) begin
        check("R8 shadow first read", {7'b0, rimData[3]}, {7'b0, en});
        rim();
        check("R8 current after read", {7'b0, rimData[3]}, 8'h00);
      end else if (expTake) begin
        check("R7 enable cleared", {7'b0, rimData[3]}, 8'h00);
      end
      if (expVec == 8'h3C)
        check("R4 latch cleared on service", {7'b0, rimData[6]}, 8'h00);
    end

    // R2: pending source, no boundary, nothing taken
    doReset();
    sim(8'h08);
    ei();
    rst55In = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R2 no take without boundary", {7'b0, irqTaken}, 8'h00);
    end
    hitBoundary();
    check("R2 take after boundary", {7'b0, irqTaken}, 8'h01);
    @(negedge clk);
    check("R2 pulse one cycle", {7'b0, irqTaken}, 8'h00);
    // R7: enable was cleared, the still-high input is not retaken
    hitBoundary();
    check("R7 not retaken while disabled", {7'b0, irqTaken}, 8'h00);
    ei();
    di();
    check("R7 diReq clears enable", {7'b0, rimData[3]}, 8'h00);

    // R6: TRAP held high is taken once, then needs low/high
    doReset();
    trapIn = 1'b1;
    waitCycles(4);
    hitBoundary();
    check("R6 trap taken", vectorOut, 8'h24);
    waitCycles(2);
    hitBoundary();
    check("R6 held trap not retaken", {7'b0, irqTaken}, 8'h00);
    trapIn = 1'b0;
    waitCycles(4);
    trapIn = 1'b1;
    waitCycles(4);
    hitBoundary();
    check("R6 re-armed trap taken", {7'b0, irqTaken}, 8'h01);
    // R6: a trap that rose and fell is not taken
    doReset();
    trapIn = 1'b1;
    waitCycles(4);
    trapIn = 1'b0;
    waitCycles(4);
    hitBoundary();
    check("R6 fallen trap ignored", {7'b0, irqTaken}, 8'h00);

    // R8: saved enable shown once, then current enable
    doReset();
    ei();
    trapIn = 1'b1;
    waitCycles(4);
    hitBoundary();
    check("R8 saved enable visible", {7'b0, rimData[3]}, 8'h01);
    waitCycles(2);
    check("R8 saved enable kept until read", {7'b0, rimData[3]}, 8'h01);
    rim();
    check("R8 current enable after read", {7'b0, rimData[3]}, 8'h00);
    ei();
    check("R8 later read shows current", {7'b0, rimData[3]}, 8'h01);

    // R4 R5: capture while masked, clear by write, clear by reset
    doReset();
    rst75In = 1'b1;
    waitCycles(3);
    rst75In = 1'b0;
    waitCycles(3);
    check("R4 captured while masked", {7'b0, rimData[6]}, 8'h01);
    sim(8'h10);
    check("R5 write clears latch", {7'b0, rimData[6]}, 8'h00);
    rst75In = 1'b1;
    waitCycles(3);
    rst75In = 1'b0;
    waitCycles(3);
    doReset();
    check("R5 reset clears latch", {7'b0, rimData[6]}, 8'h00);
    // R4 R1: masked latch stays pending while a lower restart is served
    rst75In = 1'b1;
    waitCycles(3);
    rst75In = 1'b0;
    sim(8'h0C);
    ei();
    rst65In = 1'b1;
    waitCycles(3);
    hitBoundary();
    check("R1 lower restart served", vectorOut, 8'h34);
    check("R4 masked latch still pending", {7'b0, rimData[6]}, 8'h01);

    // R9: write without load bit keeps masks
    doReset();
    sim(8'h00);
    check("R9 masks kept", {5'b0, rimData[2:0]}, 8'h07);
    sim(8'h0A);
    check("R9 masks loaded", {5'b0, rimData[2:0]}, 8'h02);

    // R10: SOD update only with enable bit
    sim(8'hC0);
    check("R10 sod set", {7'b0, sodOut}, 8'h01);
    sim(8'h00);
    check("R10 sod kept", {7'b0, sodOut}, 8'h01);
    sim(8'h40);
    check("R10 sod cleared", {7'b0, sodOut}, 8'h00);

    // R12 R11: synchronizer latency, SID in bit 7
    doReset();
    @(negedge clk);
    sidIn = 1'b1;
    rst55In = 1'b1;
    @(negedge clk);
    check("R12 not visible after one edge", {6'b0, rimData[7], rimData[4]}, 8'h00);
    @(negedge clk);
    check("R12 R11 visible after two edges", {6'b0, rimData[7], rimData[4]}, 8'h03);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule